// File: doc/BRIEF.md
# Counter Access Privilege Checker

This block judges accesses to the counter family of control registers. Given a 12-bit register address, the hart's current privilege level, which optional extensions are present, whether the register width is 32 bits, and the two 32-bit counter-enable masks (the machine mask and the supervisor mask), it reports three things. The first is whether the address names a counter-family register that exists in this configuration. The second is whether the current privilege may read it. The third is whether the access is legal overall. The trap logic consumes these flags. The counters themselves live elsewhere.

The address's low five bits form a slot index from 0 to 31. One indexed lookup into the enable masks serves every user-visible counter, both low and upper halves. Access rights are granted in two levels. Supervisor code needs the machine bit. User code needs the machine bit, and also needs the supervisor bit unless supervisor mode is absent. The three result flags are registered, so they appear one clock after the inputs.

Top module: `ctr_access_guard`

## Requirements
- R1: An address outside 0xC00..0xC1F and 0xC80..0xC9F is not a user counter, and allowed_o is 1 for it at every privilege.
- R2: With priv_i = 2'b11 (machine), allowed_o is 1 for every user counter address.
- R3: With priv_i = 2'b01 (supervisor), a user counter address is allowed exactly when mcen_i[addr[4:0]] is 1.
- R4: With priv_i = 2'b00 (user), a user counter address is allowed exactly when mcen_i[addr[4:0]] is 1 and either has_smode_i is 0 or scen_i[addr[4:0]] is 1.
- R5: Upper-half user counters (0xC80..0xC9F) are gated by the same index addr[4:0] as their low halves.
- R6: User counters 0xC03..0xC1F are defined only when hpm_en_i and has_umode_i are both 1. Slots 0xC00..0xC02 are defined when has_umode_i is 1.
- R7: Upper-half user counters 0xC80..0xC9F follow R6 and in addition require xlen32_i = 1.
- R8: Machine counters 0xB03..0xB1F and event selectors 0x323..0x33F are defined exactly when hpm_en_i is 1. Machine upper halves 0xB83..0xB9F also require xlen32_i. Event slots 0x320..0x322 are not defined by this block.
- R9: 0xB00 and 0xB02 are always defined, and 0xB80 and 0xB82 are defined exactly when xlen32_i is 1. 0xB01, 0xB81 and any address outside the listed families give defined_o = 0.
- R10: legal_o equals defined_o AND allowed_o.
- R11: priv_i = 2'b10 is reserved and denies every user counter address.
- R12: The flags are registered with one clock of latency, and an active-low reset clears all three to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| csr_addr_i | input | 12 | Register address being accessed |
| priv_i | input | 2 | Current privilege: 00 user, 01 supervisor, 11 machine, 10 reserved |
| has_smode_i | input | 1 | Supervisor mode is implemented |
| has_umode_i | input | 1 | User mode is implemented |
| hpm_en_i | input | 1 | Performance-counter extension is enabled |
| xlen32_i | input | 1 | Register width is 32 bits |
| mcen_i | input | 32 | Machine counter-enable mask |
| scen_i | input | 32 | Supervisor counter-enable mask |
| defined_o | output | 1 | Address names an existing counter-family register |
| allowed_o | output | 1 | Current privilege may access the address |
| legal_o | output | 1 | defined_o AND allowed_o |

## Verification
The checker enforces the following relations on every cycle, each against the inputs of the previous cycle:
- the pass-through for non-counter addresses;
- the machine-mode grant;
- the supervisor denial when the machine bit is clear;
- the user denial when either mask bit is clear;
- the reserved-privilege denial;
- the 32-bit condition on upper halves;
- the combination rule for legal_o.

Some behaviour only the bench scenarios can show:
- the exact definedness map across all five address families and all 32 slots, under every extension combination;
- that grants are positive as well as negative;
- the one-clock latency and the reset values.

// File: rtl/ctr_priv_pkg.sv
package ctr_priv_pkg;

    localparam int unsigned CSR_AW     = 12;
    localparam int unsigned SLOT_CNT   = 32;
    localparam int unsigned SLOT_IW    = $clog2(SLOT_CNT);
    localparam int unsigned PREFIX_W   = CSR_AW - SLOT_IW;
    localparam int unsigned FIRST_HPM  = 3;

    // address prefixes (addr[11:5]) of the counter families
    localparam logic [PREFIX_W-1:0] PFX_USER_LO = 7'b1100000;
    localparam logic [PREFIX_W-1:0] PFX_USER_HI = 7'b1100100;
    localparam logic [PREFIX_W-1:0] PFX_MACH_LO = 7'b1011000;
    localparam logic [PREFIX_W-1:0] PFX_MACH_HI = 7'b1011100;
    localparam logic [PREFIX_W-1:0] PFX_EVENT   = 7'b0011001;

    typedef enum logic [1:0] {
        PRIV_USER = 2'b00,
        PRIV_SUPV = 2'b01,
        PRIV_RSVD = 2'b10,
        PRIV_MACH = 2'b11
    } priv_e;

    typedef enum logic [2:0] {
        FAM_NONE    = 3'd0,
        FAM_USER_LO = 3'd1,
        FAM_USER_HI = 3'd2,
        FAM_MACH_LO = 3'd3,
        FAM_MACH_HI = 3'd4,
        FAM_EVENT   = 3'd5
    } fam_e;

    typedef struct packed {
        logic defined;
        logic allowed;
        logic legal;
    } verdict_t;

endpackage

// File: rtl/ctr_addr_decode.sv
module ctr_addr_decode
    import ctr_priv_pkg::*;
#(
    parameter int unsigned ADDR_W = CSR_AW,
    parameter int unsigned IDX_W  = SLOT_IW
) (
    input  logic [ADDR_W-1:0] addr_i,
    output fam_e              fam_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              hpm_slot_o
);
    localparam int unsigned PW = ADDR_W - IDX_W;

    logic [PW-1:0] prefix;

    always_comb begin
        prefix     = addr_i[ADDR_W-1:IDX_W];
        idx_o      = addr_i[IDX_W-1:0];
        hpm_slot_o = (idx_o >= IDX_W'(FIRST_HPM));
        unique case (prefix)
            PFX_USER_LO: fam_o = FAM_USER_LO;
            PFX_USER_HI: fam_o = FAM_USER_HI;
            PFX_MACH_LO: fam_o = FAM_MACH_LO;
            PFX_MACH_HI: fam_o = FAM_MACH_HI;
            PFX_EVENT:   fam_o = FAM_EVENT;
            default:     fam_o = FAM_NONE;
        endcase
    end
endmodule

// File: rtl/ctr_defined_map.sv
module ctr_defined_map
    import ctr_priv_pkg::*;
#(
    parameter int unsigned IDX_W = SLOT_IW
) (
    input  fam_e             fam_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic             hpm_slot_i,
    input  logic             has_umode_i,
    input  logic             hpm_en_i,
    input  logic             xlen32_i,
    output logic             defined_o
);
    logic user_slot_ok;
    logic mach_slot_ok;
    logic fixed_mach;

    always_comb begin
        // slots 0 and 2 of the machine family are the fixed cycle/retire counters
        fixed_mach   = (idx_i == IDX_W'(0)) || (idx_i == IDX_W'(2));
        user_slot_ok = has_umode_i && (hpm_slot_i ? hpm_en_i : 1'b1);
        mach_slot_ok = hpm_slot_i ? hpm_en_i : fixed_mach;
        unique case (fam_i)
            FAM_USER_LO: defined_o = user_slot_ok;
            FAM_USER_HI: defined_o = user_slot_ok && xlen32_i;
            FAM_MACH_LO: defined_o = mach_slot_ok;
            FAM_MACH_HI: defined_o = mach_slot_ok && xlen32_i;
            FAM_EVENT:   defined_o = hpm_slot_i && hpm_en_i;
            default:     defined_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/ctr_enable_gate.sv
module ctr_enable_gate
    import ctr_priv_pkg::*;
#(
    parameter int unsigned SLOTS = SLOT_CNT,
    parameter int unsigned IDX_W = $clog2(SLOTS)
) (
    input  fam_e             fam_i,
    input  logic [IDX_W-1:0] idx_i,
    input  priv_e            priv_i,
    input  logic             has_smode_i,
    input  logic [SLOTS-1:0] mcen_i,
    input  logic [SLOTS-1:0] scen_i,
    output logic             allowed_o
);
    logic [SLOTS-1:0] supv_ok;
    logic [SLOTS-1:0] user_ok;
    logic             is_user_ctr;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        assign supv_ok[g] = mcen_i[g];
        assign user_ok[g] = mcen_i[g] && (!has_smode_i || scen_i[g]);
    end

    always_comb begin
        is_user_ctr = (fam_i == FAM_USER_LO) || (fam_i == FAM_USER_HI);
        if (!is_user_ctr) begin
            allowed_o = 1'b1;
        end else begin
            unique case (priv_i)
                PRIV_MACH: allowed_o = 1'b1;
                PRIV_SUPV: allowed_o = supv_ok[idx_i];
                PRIV_USER: allowed_o = user_ok[idx_i];
                default:   allowed_o = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/ctr_access_guard.sv
module ctr_access_guard
    import ctr_priv_pkg::*;
#(
    parameter int unsigned ADDR_W = CSR_AW,
    parameter int unsigned SLOTS  = SLOT_CNT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [1:0]        priv_i,
    input  logic              has_smode_i,
    input  logic              has_umode_i,
    input  logic              hpm_en_i,
    input  logic              xlen32_i,
    input  logic [SLOTS-1:0]  mcen_i,
    input  logic [SLOTS-1:0]  scen_i,
    output logic              defined_o,
    output logic              allowed_o,
    output logic              legal_o
);
    localparam int unsigned IDX_W = $clog2(SLOTS);

    fam_e             fam;
    logic [IDX_W-1:0] idx;
    logic             hpm_slot;
    logic             def_w;
    logic             alw_w;
    priv_e            priv;
    verdict_t         st_d;
    verdict_t         st_q;

    assign priv = priv_e'(priv_i);

    ctr_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) decode_i (
        .addr_i     (csr_addr_i),
        .fam_o      (fam),
        .idx_o      (idx),
        .hpm_slot_o (hpm_slot)
    );

    ctr_defined_map #(.IDX_W(IDX_W)) defmap_i (
        .fam_i       (fam),
        .idx_i       (idx),
        .hpm_slot_i  (hpm_slot),
        .has_umode_i (has_umode_i),
        .hpm_en_i    (hpm_en_i),
        .xlen32_i    (xlen32_i),
        .defined_o   (def_w)
    );

    ctr_enable_gate #(.SLOTS(SLOTS), .IDX_W(IDX_W)) gate_i (
        .fam_i       (fam),
        .idx_i       (idx),
        .priv_i      (priv),
        .has_smode_i (has_smode_i),
        .mcen_i      (mcen_i),
        .scen_i      (scen_i),
        .allowed_o   (alw_w)
    );

    always_comb begin
        st_d.defined = def_w;
        st_d.allowed = alw_w;
        st_d.legal   = def_w && alw_w;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign defined_o = st_q.defined;
    assign allowed_o = st_q.allowed;
    assign legal_o   = st_q.legal;
endmodule

// File: rtl/ctr_access_guard_chk.sv
module ctr_access_guard_chk #(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned SLOTS  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] csr_addr_i,
    input logic [1:0]        priv_i,
    input logic              has_smode_i,
    input logic              has_umode_i,
    input logic              hpm_en_i,
    input logic              xlen32_i,
    input logic [SLOTS-1:0]  mcen_i,
    input logic [SLOTS-1:0]  scen_i,
    input logic              defined_o,
    input logic              allowed_o,
    input logic              legal_o
);
    logic       user_ctr;
    logic       upper_half;
    logic [4:0] slot;

    assign slot       = csr_addr_i[4:0];
    assign user_ctr   = (csr_addr_i >= 12'hC00 && csr_addr_i <= 12'hC1F) ||
                        (csr_addr_i >= 12'hC80 && csr_addr_i <= 12'hC9F);
    assign upper_half = (csr_addr_i >= 12'hC80 && csr_addr_i <= 12'hC9F);

    AST_NONCTR_PASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !user_ctr |=> allowed_o); // R1

    AST_MACH_GRANT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_ctr && priv_i == 2'b11) |=> allowed_o); // R2

    AST_SUPV_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_ctr && priv_i == 2'b01 && !mcen_i[slot]) |=> !allowed_o); // R3

    AST_USER_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_ctr && priv_i == 2'b00 && (!mcen_i[slot] || (has_smode_i && !scen_i[slot])))
        |=> !allowed_o); // R4

    AST_UPPER_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (upper_half && !xlen32_i) |=> !defined_o); // R7

    AST_USER_NO_UMODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_ctr && !has_umode_i) |=> !defined_o); // R6

    AST_LEGAL_COMBINE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        legal_o == (defined_o && allowed_o)); // R10

    AST_RSVD_PRIV: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (user_ctr && priv_i == 2'b10) |=> !allowed_o); // R11

    AST_EVT_LOW_SLOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (csr_addr_i >= 12'h320 && csr_addr_i <= 12'h322) |=> !defined_o); // R8
endmodule

bind ctr_access_guard ctr_access_guard_chk #(.ADDR_W(ADDR_W), .SLOTS(SLOTS)) chk_i (.*);

// File: tb/ctr_access_guard_tb_top.sv
module ctr_access_guard_tb_top;
    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic [11:0] csr_addr_i = '0;
    logic [1:0]  priv_i = '0;
    logic        has_smode_i = 1'b0;
    logic        has_umode_i = 1'b0;
    logic        hpm_en_i = 1'b0;
    logic        xlen32_i = 1'b0;
    logic [31:0] mcen_i = '0;
    logic [31:0] scen_i = '0;
    logic        defined_o, allowed_o, legal_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2 clk_i = ~clk_i;

    ctr_access_guard dut_i (.*);

    // independent reference of the requirements
    function automatic bit ref_defined(input logic [11:0] a, input bit u, input bit h, input bit x);
        int s = int'(a[4:0]);
        if (a >= 12'hC00 && a <= 12'hC1F) return u && (s < 3 || h);             // R6
        if (a >= 12'hC80 && a <= 12'hC9F) return u && (s < 3 || h) && x;        // R7
        if (a >= 12'hB00 && a <= 12'hB1F) return (s >= 3) ? h : (s != 1);       // R8 R9
        if (a >= 12'hB80 && a <= 12'hB9F) return ((s >= 3) ? h : (s != 1)) && x;
        if (a >= 12'h320 && a <= 12'h33F) return (s >= 3) && h;                 // R8
        return 1'b0;                                                            // R9
    endfunction

    function automatic bit ref_allowed(input logic [11:0] a, input logic [1:0] p,
                                       input bit hs, input logic [31:0] m, input logic [31:0] sv);
        int s = int'(a[4:0]);
        bit ctr = (a >= 12'hC00 && a <= 12'hC1F) || (a >= 12'hC80 && a <= 12'hC9F);
        if (!ctr) return 1'b1;                       // R1
        case (p)
            2'b11: return 1'b1;                      // R2
            2'b01: return m[s];                      // R3
            2'b00: return m[s] && (!hs || sv[s]);    // R4 R5
            default: return 1'b0;                    // R11
        endcase
    endfunction

    task automatic cmp(input string tag, input logic act, input logic exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h priv=%b s=%b u=%b h=%b x=%b actual=%b expected=%b",
                     tag, csr_addr_i, priv_i, has_smode_i, has_umode_i, hpm_en_i, xlen32_i, act, exp);
        end
    endtask

    task automatic apply_check(input logic [11:0] a, input logic [1:0] p, input logic [3:0] ext,
                               input logic [31:0] m, input logic [31:0] sv, input string tag_a);
        bit ed, ea;
        @(negedge clk_i);
        csr_addr_i  = a;  priv_i = p;
        has_smode_i = ext[0]; has_umode_i = ext[1]; hpm_en_i = ext[2]; xlen32_i = ext[3];
        mcen_i = m; scen_i = sv;
        ed = ref_defined(a, ext[1], ext[2], ext[3]);
        ea = ref_allowed(a, p, ext[0], m, sv);
        @(posedge clk_i); #1;
        cmp("R6/R7/R8/R9 defined", defined_o, ed);
        cmp(tag_a, allowed_o, ea);
        cmp("R10 legal", legal_o, ed && ea);
    endtask

    // R12: reset state and one-cycle latency
    task automatic t_reset_latency();
        #1;
        cmp("R12 reset defined", defined_o, 1'b0);
        cmp("R12 reset allowed", allowed_o, 1'b0);
        cmp("R12 reset legal", legal_o, 1'b0);
        @(negedge clk_i); rst_ni = 1'b1;
        csr_addr_i = 12'hB00; priv_i = 2'b11;
        #1;
        cmp("R12 before edge", legal_o, 1'b0);
        @(posedge clk_i); #1;
        cmp("R12 after edge", legal_o, 1'b1);
    endtask

    // R1: non-counter addresses, every privilege
    task automatic t_non_counter();
        logic [11:0] addrs [6] = '{12'h000, 12'h300, 12'hBFF, 12'hC20, 12'hC7F, 12'hCA0};
        for (int i = 0; i < 6; i++)
            for (int p = 0; p < 4; p++)
                apply_check(addrs[i], 2'(p), 4'b1111, 32'h0, 32'h0, "R1 non-counter allowed");
    endtask

    // R2..R11: full sweep over families, slots, privileges and extension sets
    task automatic t_sweep();
        logic [11:0] bases [5] = '{12'hC00, 12'hC80, 12'hB00, 12'hB80, 12'h320};
        for (int e = 0; e < 16; e++) begin
            logic [31:0] m  = {32'h6D2B_79F4 << e} | {32'h6D2B_79F4 >> (32 - e)};
            logic [31:0] sv = {32'hB3C5_1E8A >> e} | {32'hB3C5_1E8A << (32 - e)};
            if (e == 0) begin m = 32'h6D2B_79F4; sv = 32'hB3C5_1E8A; end
            for (int b = 0; b < 5; b++)
                for (int p = 0; p < 4; p++)
                    for (int s = 0; s < 32; s++) begin
                        string t;
                        case (p)
                            3: t = "R2 machine allowed";
                            1: t = "R3 supervisor allowed";
                            0: t = (b == 1) ? "R5 upper user allowed" : "R4 user allowed";
                            default: t = "R11 reserved allowed";
                        endcase
                        if (b >= 2) t = "R1 non-user family allowed";
                        apply_check(bases[b] | 12'(s), 2'(p), 4'(e), m, sv, t);
                    end
        end
    endtask

    // R5: low and upper half of one slot see the same mask bit
    task automatic t_upper_index();
        for (int s = 0; s < 32; s++) begin
            logic [31:0] m = 32'h1 << s;
            apply_check(12'hC80 | 12'(s), 2'b01, 4'b1111, m, 32'h0, "R5 upper uses slot bit");
            apply_check(12'hC80 | 12'(s), 2'b01, 4'b1111, ~m, 32'h0, "R5 upper other bits ignored");
        end
    endtask

    initial begin
        t_reset_latency();
        t_non_counter();
        t_upper_index();
        t_sweep();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk_i);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule